// File: doc/BRIEF.md
# Opcode Field Decoder and Legality Checker

This block takes one 16-bit instruction word of a small 32-instruction processor. It splits the word into named fields, works out which register each operand selects, and widens the short constant carried by the quick forms. It also checks whether the word is legal for its opcode. The checks cover the operand-count bit, the size field and the addressing modes. When a rule is broken, exactly one error flag is raised, and a halt request goes to the controller.

Instruction words use one of two layouts. The two-reference layout has a source mode/register pair and a destination mode/register pair. The immediate layout puts a 4-bit constant where the source pair would sit. The opcode alone chooses the layout.

The decode logic is purely combinational. A parameter selects an optional register stage on every output. With the stage in place, results appear one clock after the word is presented, and reset clears them to zero.

Top module: `instr_decode_check`

## Requirements
- R1: The outputs carry the following bit fields of the word. The opcode name is bits 15..11 and the size code is bits 9..8. The destination mode is bits 3..1. In the two-reference layout, the source mode is bits 7..5.
- R2: The immediate layout is flagged (imm_fmt_o=1) for exactly the opcode names 00001, 00011, 01100, 01101, 01110, 01111 and 11001.
- R3: In the immediate layout, imm_o equals bits 7..4 zero-extended to IMM_W bits. In that layout the source mode and all source register selects read 0. In the two-reference layout, imm_o is 0.
- R4: Register selects depend on the operand's mode, using bit 4 (source) or bit 0 (destination) as the index. Mode 000 raises the data-register select. Modes 001, 100, 110 and 111 raise the address-register select. Any other mode raises neither select, and the index then reads 0.
- R5: An operand-count error is raised when bit 10 differs from 1 for the two-operand opcodes and 0 for all others. The two-operand opcodes are 00000, 00010, 00100, 00101, 01001, 01010, 01011, 10000, 11000, 11010 and 11011.
- R6: A size error is raised when the size code is 11 for any opcode. It is also raised when the size code falls outside the opcode's allowed set. Size codes are 00 byte, 01 word and 10 long. Opcode 00100 and opcodes 10010..10111 and 11011 allow word only. Opcodes 00101 and 11010 allow long only. All others allow the three sizes.
- R7: Certain words raise a mode error. For opcodes 10010..10111 and 11011, this happens when the source mode (bits 7..5) is not 011. For opcode 11010, it happens when either mode is outside {000, 001}.
- R8: Only one error flag is set at a time. The count error takes precedence over the size error, and the size error over the mode error.
- R9: halt_req_o is high exactly when one of the error flags is high.
- R10: With REG_OUT=1, every output reflects the word presented one clock earlier, and all outputs read 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| opcode_i | input | 16 | Instruction word to decode |
| op_name_o | output | 5 | Opcode name field |
| size_o | output | 2 | Size code |
| imm_fmt_o | output | 1 | Word uses the immediate layout |
| mode1_o | output | 3 | Source addressing mode (0 in immediate layout) |
| mode2_o | output | 3 | Destination addressing mode |
| op1_dreg_o | output | 1 | Source selects a data register |
| op1_areg_o | output | 1 | Source selects an address register |
| op1_idx_o | output | 1 | Source register index |
| op2_dreg_o | output | 1 | Destination selects a data register |
| op2_areg_o | output | 1 | Destination selects an address register |
| op2_idx_o | output | 1 | Destination register index |
| imm_o | output | IMM_W | Zero-extended immediate constant |
| err_count_o | output | 1 | Operand-count bit is wrong |
| err_size_o | output | 1 | Size code not allowed |
| err_mode_o | output | 1 | Addressing mode not allowed |
| halt_req_o | output | 1 | Any error present |

## Verification
The bench sweeps all 65,536 instruction words through the registered configuration. This covers every opcode with every size code, every count-bit value and every pair of modes. The sweep separates layout-dependent field handling (immediate versus two-reference) from the register-select mapping for all eight modes. The error checks are compared separately, so a wrong allowed-size set, a missed mode rule or a broken priority between simultaneous violations each appears under its own requirement. A check while reset is held confirms that the output stage clears.

// File: rtl/instr_decode_check.sv
module instr_decode_check #(
  parameter int IMM_W   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      opcode_i,
  output logic [4:0]       op_name_o,
  output logic [1:0]       size_o,
  output logic             imm_fmt_o,
  output logic [2:0]       mode1_o,
  output logic [2:0]       mode2_o,
  output logic             op1_dreg_o,
  output logic             op1_areg_o,
  output logic             op1_idx_o,
  output logic             op2_dreg_o,
  output logic             op2_areg_o,
  output logic             op2_idx_o,
  output logic [IMM_W-1:0] imm_o,
  output logic             err_count_o,
  output logic             err_size_o,
  output logic             err_mode_o,
  output logic             halt_req_o
);

  localparam int OUT_W = 24 + IMM_W;

  logic [4:0] name;
  logic [1:0] ds;
  logic       pbit;
  logic [2:0] m1_raw, m1, m2;
  logic       n1, n2;
  logic       imm_fmt, two_ops, size_ok, branch_like, exg;
  logic       bad_cnt, bad_sz, bad_md;
  logic       e_cnt, e_sz, e_md;
  logic       d1, a1, d2, a2;
  logic [IMM_W-1:0] imm;
  logic [OUT_W-1:0] nxt, cur;

  assign name   = opcode_i[15:11];
  assign pbit   = opcode_i[10];
  assign ds     = opcode_i[9:8];
  assign m1_raw = opcode_i[7:5];
  assign m2     = opcode_i[3:1];
  assign n2     = opcode_i[0];

  always_comb begin
    case (name)
      5'd1, 5'd3, 5'd12, 5'd13, 5'd14, 5'd15, 5'd25: imm_fmt = 1'b1;
      default:                                      imm_fmt = 1'b0;
    endcase
  end

  assign m1 = imm_fmt ? 3'b000 : m1_raw;
  assign n1 = imm_fmt ? 1'b0 : opcode_i[4];

  assign d1 = !imm_fmt && (m1 == 3'b000);
  assign a1 = !imm_fmt && (m1 == 3'b001 || m1 == 3'b100 || m1 == 3'b110 || m1 == 3'b111);
  assign d2 = (m2 == 3'b000);
  assign a2 = (m2 == 3'b001 || m2 == 3'b100 || m2 == 3'b110 || m2 == 3'b111);

  assign imm = imm_fmt ? {{(IMM_W-4){1'b0}}, opcode_i[7:4]} : '0;

  always_comb begin
    case (name)
      5'd0, 5'd2, 5'd4, 5'd5, 5'd9, 5'd10, 5'd11,
      5'd16, 5'd24, 5'd26, 5'd27: two_ops = 1'b1;
      default:                    two_ops = 1'b0;
    endcase
  end

  assign branch_like = (name >= 5'd18 && name <= 5'd23) || name == 5'd27;
  assign exg         = (name == 5'd26);

  always_comb begin
    if (ds == 2'b11)                        size_ok = 1'b0;
    else if (name == 5'd4 || branch_like)   size_ok = (ds == 2'b01);
    else if (name == 5'd5 || exg)           size_ok = (ds == 2'b10);
    else                                    size_ok = 1'b1;
  end

  assign bad_cnt = (pbit != two_ops);
  assign bad_sz  = !size_ok;
  assign bad_md  = (branch_like && m1_raw != 3'b011) ||
                   (exg && (m1_raw[2:1] != 2'b00 || m2[2:1] != 2'b00));

  assign e_cnt = bad_cnt;
  assign e_sz  = !bad_cnt && bad_sz;
  assign e_md  = !bad_cnt && !bad_sz && bad_md;

  assign nxt = {name, ds, imm_fmt, m1, m2,
                d1, a1, n1 & (d1 | a1),
                d2, a2, n2 & (d2 | a2),
                imm, e_cnt, e_sz, e_md, e_cnt | e_sz | e_md};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
      end
    end else begin : g_comb
      assign cur = nxt;
    end
  endgenerate

  assign {op_name_o, size_o, imm_fmt_o, mode1_o, mode2_o,
          op1_dreg_o, op1_areg_o, op1_idx_o,
          op2_dreg_o, op2_areg_o, op2_idx_o,
          imm_o, err_count_o, err_size_o, err_mode_o, halt_req_o} = cur;

  always_comb begin
    if (!$isunknown(opcode_i)) begin
      a_r8_single_err: assert ($onehot0({e_cnt, e_sz, e_md}));
      a_r6_ds11_flags: assert (!(ds == 2'b11 && !bad_cnt) || e_sz);
      a_r3_imm_narrow: assert (imm[IMM_W-1:4] == '0);
      a_r4_excl_sel:   assert (!(d1 && a1) && !(d2 && a2));
    end
  end

  generate
    if (REG_OUT) begin : g_chk
      a_r10_name_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> op_name_o == $past(opcode_i[15:11]));
      a_r9_halt_any: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req_o == (err_count_o | err_size_o | err_mode_o));
      a_r7_branch_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i[15:11] == 5'd18 && opcode_i[10:8] == 3'b001 && opcode_i[7:5] != 3'b011)
          |=> err_mode_o);
    end
  endgenerate

endmodule

// File: tb/instr_decode_check_tb.sv
module instr_decode_check_tb_top;
  localparam int IMM_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [4:0] op_name_o;
  logic [1:0] size_o;
  logic imm_fmt_o;
  logic [2:0] mode1_o, mode2_o;
  logic op1_dreg_o, op1_areg_o, op1_idx_o, op2_dreg_o, op2_areg_o, op2_idx_o;
  logic [IMM_W-1:0] imm_o;
  logic err_count_o, err_size_o, err_mode_o, halt_req_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  instr_decode_check #(.IMM_W(IMM_W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i),
    .op_name_o(op_name_o), .size_o(size_o), .imm_fmt_o(imm_fmt_o),
    .mode1_o(mode1_o), .mode2_o(mode2_o),
    .op1_dreg_o(op1_dreg_o), .op1_areg_o(op1_areg_o), .op1_idx_o(op1_idx_o),
    .op2_dreg_o(op2_dreg_o), .op2_areg_o(op2_areg_o), .op2_idx_o(op2_idx_o),
    .imm_o(imm_o), .err_count_o(err_count_o), .err_size_o(err_size_o),
    .err_mode_o(err_mode_o), .halt_req_o(halt_req_o));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp, input logic [15:0] w);
    total++;
    if (act !== exp) begin
      bad++;
      if (bad < 20)
        $display("FAIL %s word=%h actual=%h expected=%h", tag, w, act, exp);
    end
  endtask

  function automatic logic [2:0] sel(input logic [2:0] m, input logic n);
    logic d, a;
    d = (m == 3'd0);
    a = (m == 3'd1) || (m == 3'd4) || (m == 3'd6) || (m == 3'd7);
    return {d, a, n & (d | a)};
  endfunction

  initial begin : wd
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    opcode_i = 16'hFFFF;
    @(negedge clk);
    check("R10 reset", {7'd0, op_name_o, size_o, imm_fmt_o, halt_req_o, imm_o},
          64'd0, opcode_i);
    rst_n = 1'b1;
    for (int w = 0; w < 65536; w++) begin
      logic [15:0] op;
      int nm, cnt_exp, wmask;
      logic isimm, e1, e2, e3, c, s, md;
      logic [2:0] m1e, s1, s2;
      logic [IMM_W-1:0] ie;
      op = w[15:0];
      opcode_i = op;
      @(negedge clk);
      nm = op[15:11];
      isimm = (nm == 1 || nm == 3 || nm == 25 || (nm >= 12 && nm <= 15));
      m1e = isimm ? 3'd0 : op[7:5];
      ie = isimm ? IMM_W'(op[7:4]) : '0;
      s1 = isimm ? 3'd0 : sel(op[7:5], op[4]);
      s2 = sel(op[3:1], op[0]);
      cnt_exp = (nm == 0 || nm == 2 || nm == 4 || nm == 5 || nm == 9 || nm == 10 ||
                 nm == 11 || nm == 16 || nm == 24 || nm == 26 || nm == 27) ? 1 : 0;
      // allowed sizes as a mask: bit0 byte, bit1 word, bit2 long
      if (nm == 4 || nm == 27 || (nm >= 18 && nm <= 23)) wmask = 2;
      else if (nm == 5 || nm == 26) wmask = 4;
      else wmask = 7;
      c = (int'(op[10]) != cnt_exp);
      s = (op[9:8] == 2'b11) || ((wmask >> op[9:8]) & 1) == 0;
      md = ((nm >= 18 && nm <= 23) || nm == 27) ? (op[7:5] != 3'b011) :
           (nm == 26) ? (op[7:5] > 3'd1 || op[3:1] > 3'd1) : 1'b0;
      e1 = c; e2 = !c && s; e3 = !c && !s && md;
      check("R1 fields", {op_name_o, size_o, mode2_o}, {op[15:11], op[9:8], op[3:1]}, op);
      check("R2 format", imm_fmt_o, isimm, op);
      check("R3 imm/src", {imm_o, mode1_o}, {ie, m1e}, op);
      check("R4 selects", {op1_dreg_o, op1_areg_o, op1_idx_o, op2_dreg_o, op2_areg_o, op2_idx_o},
            {s1, s2}, op);
      check("R5 count", err_count_o, e1, op);
      check("R6 size", err_size_o, e2, op);
      check("R7 mode", err_mode_o, e3, op);
      check("R8 onehot", (err_count_o + err_size_o + err_mode_o) <= 1, 1, op);
      check("R9 halt", halt_req_o, e1 | e2 | e3, op);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule